// File: doc/BRIEF.md
# Configuration Space Address Translator

This block sits between configuration-access software and the memory-mapped register space of a root complex with several root ports. It accepts one configuration request at a time. A request names a bus, a device, a function, a 12-bit register offset, an access size and, for writes, the data. The block turns the request into a 32-bit word address, runs the memory access and returns a one-cycle completion that carries the read data and an error flag.

Requests on bus 0 are sent to the register window of a root port. The port is picked by device number, with device N selecting port N-1. Requests on any other bus go to a shared extended-configuration window at a packed offset, and the upper bits of the register offset land at the top of that offset. A request that cannot be mapped never reaches memory. If it is a read it returns all ones, and if it is a write it is dropped. Byte and halfword writes are done as a read of the whole word, a merge and a write-back. A legacy strap restricts downstream buses to device 0 and makes the root ports report the bridge class code.

Top module: `cfg_xlate_top`

## Requirements
- R1: On bus 0, device N with N from 1 to NUM_PORTS selects port N-1 if that port's enable bit is set. The address is that port's base plus the register offset with bits [1:0] cleared. All 12 offset bits are used.
- R2: A bus 0 request whose device number selects no enabled port is an error. This includes device 0, devices above NUM_PORTS and disabled ports.
- R3: On a non-zero bus the address is the window base plus the sum of five parts: offset[11:8] at bits [27:24], bus at [23:16], device at [15:11], function at [10:8], and offset[7:2] at [7:2].
- R4: While the legacy strap is high, a request on a non-zero bus with a device number other than 0 is an error. Device 0 on such a bus is still mapped as in R3.
- R5: While the legacy strap is high, a successful bus 0 read of the dword at offset 0x08 returns bits [23:16] as 0x04 and all other bits unchanged. The fixup is not applied on other buses, when the strap is low, or to error reads.
- R6: An error read completes with the error flag set and issues no memory access. Its data is all ones within the access size: 0xFF for a byte, 0xFFFF for a halfword, 0xFFFFFFFF for a word.
- R7: An error write completes with the error flag set and issues no memory access of any kind.
- R8: A mapped write first reads the word at the translated address and then writes back to the same address. For size 0 (byte) the write-back is the old word with lane offset[1:0] replaced by wdata[7:0]. For size 1 (halfword) it is the old word with halfword offset[1] replaced by wdata[15:0]. For size 2 (word) it is wdata.
- R9: A mapped byte read returns the byte at lane offset[1:0], and a halfword read returns the halfword at offset[1]. In both cases the result sits at bit 0 and the upper bits are zero. A word read returns the whole word.
- R10: req_ready is high only while the block is idle. mem_req stays high, with mem_addr and mem_we stable, until mem_ack. done is high for exactly one cycle per accepted request.
- R11: During and right after reset, req_ready is 1 and mem_req and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Legacy strap: downstream device 0 only, bridge class fixup |
| port_en | input | NUM_PORTS | Enable bit per root port |
| port_base | input | NUM_PORTS*AW | Register window base per root port, port 0 in the low bits |
| ext_base | input | AW | Extended-configuration window base |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 12 | Register offset in bytes |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, right-aligned |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | 32 | Word written back |
| mem_ack | input | 1 | Memory access complete, read data valid |
| mem_rdata | input | 32 | Word read |
| done | output | 1 | Completion pulse |
| done_err | output | 1 | Request could not be mapped |
| done_rdata | output | 32 | Read result, right-aligned |

## Verification
The hardest behaviour to reach from the ports is the set of paths where routing depends on two things together: a disabled port behind a valid device number, and a legacy-only error or fixup that applies only on one bus and only to one dword. The stimulus table varies the strap, the bus, the device and the offset inside one access each, so every one of these combinations gets its own row. The memory model answers each read with a word computed from the address, and it records every access it sees. A wrong address therefore shows up in the read data or the write record, and an access that should never have happened shows up as a change in its counters.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int DW    = 32;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int OFF_W = 12;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_ERR,
    ST_DONE
  } xl_state_t;
endpackage

// File: rtl/cfg_xlate_decode.sv
module cfg_xlate_decode
  import cfg_xlate_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int AW        = 32
) (
  input  logic [BUS_W-1:0]        bus,
  input  logic [DEV_W-1:0]        dev,
  input  logic [FN_W-1:0]         func,
  input  logic [OFF_W-1:0]        roff,
  input  logic                    legacy,
  input  logic [NUM_PORTS-1:0]    port_en,
  input  logic [NUM_PORTS*AW-1:0] port_base,
  input  logic [AW-1:0]           ext_base,
  output logic [AW-1:0]           addr,
  output logic                    err
);
  localparam int PK_W = 28;

  logic [NUM_PORTS-1:0] hit;
  logic [AW-1:0]        sel_base;
  logic [PK_W-1:0]      packed_off;
  logic                 on_root;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign hit[i] = port_en[i] && (dev == DEV_W'(i + 1));
  end

  always_comb begin
    sel_base = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (hit[i]) sel_base = sel_base | port_base[i*AW +: AW];
    end
  end

  assign on_root    = (bus == '0);
  assign packed_off = {roff[11:8], bus, dev, func, roff[7:2], 2'b00};

  always_comb begin
    if (on_root) begin
      addr = sel_base + AW'({roff[OFF_W-1:2], 2'b00});
      err  = ~(|hit);
    end else begin
      addr = ext_base + AW'(packed_off);
      err  = legacy && (dev != '0);
    end
  end
endmodule

// File: rtl/cfg_xlate_lanes.sv
module cfg_xlate_lanes
  import cfg_xlate_pkg::*;
(
  input  logic [DW-1:0] src,
  input  logic [1:0]    size,
  input  logic [1:0]    off,
  input  logic          fix,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] merged
);
  localparam logic [7:0] BRIDGE_CLASS = 8'h04;

  logic [DW-1:0] fixed;
  logic [DW-1:0] shifted_b;
  logic [DW-1:0] shifted_h;

  assign fixed     = fix ? {src[31:24], BRIDGE_CLASS, src[15:0]} : src;
  assign shifted_b = fixed >> {off, 3'b000};
  assign shifted_h = fixed >> {off[1], 4'b0000};

  always_comb begin
    case (size)
      SZ_BYTE: rd_val = {24'h0, shifted_b[7:0]};
      SZ_HALF: rd_val = {16'h0, shifted_h[15:0]};
      default: rd_val = fixed;
    endcase
  end

  always_comb begin
    merged = src;
    case (size)
      SZ_BYTE: merged[{off, 3'b000} +: 8]     = wdata[7:0];
      SZ_HALF: merged[{off[1], 4'b0000} +: 16] = wdata[15:0];
      default: merged = wdata;
    endcase
  end
endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
  import cfg_xlate_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int AW        = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    legacy_mode,
  input  logic [NUM_PORTS-1:0]    port_en,
  input  logic [NUM_PORTS*AW-1:0] port_base,
  input  logic [AW-1:0]           ext_base,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [7:0]              req_bus,
  input  logic [4:0]              req_dev,
  input  logic [2:0]              req_func,
  input  logic [11:0]             req_off,
  input  logic [1:0]              req_size,
  input  logic [31:0]             req_wdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [31:0]             mem_wdata,
  input  logic                    mem_ack,
  input  logic [31:0]             mem_rdata,
  output logic                    done,
  output logic                    done_err,
  output logic [31:0]             done_rdata
);
  xl_state_t     st;
  logic [AW-1:0] dec_addr;
  logic          dec_err;
  logic          take;
  logic          is_fix;

  logic [AW-1:0] addr_q;
  logic          err_q, we_q, fix_q;
  logic [1:0]    size_q, off_q;
  logic [DW-1:0] wdata_q, word_q, rdata_q;

  logic [DW-1:0] lane_src, lane_rd, lane_merged;

  cfg_xlate_decode #(.NUM_PORTS(NUM_PORTS), .AW(AW)) u_dec (
    .bus(req_bus), .dev(req_dev), .func(req_func), .roff(req_off),
    .legacy(legacy_mode), .port_en(port_en), .port_base(port_base),
    .ext_base(ext_base), .addr(dec_addr), .err(dec_err)
  );

  assign lane_src = err_q ? '1 : mem_rdata;

  cfg_xlate_lanes u_lanes (
    .src(lane_src), .size(size_q), .off(off_q), .fix(fix_q),
    .wdata(wdata_q), .rd_val(lane_rd), .merged(lane_merged)
  );

  assign take   = req_valid && (st == ST_IDLE);
  assign is_fix = legacy_mode && !req_write && !dec_err &&
                  (req_bus == '0) && (req_off[11:2] == 10'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      err_q   <= 1'b0;
      we_q    <= 1'b0;
      fix_q   <= 1'b0;
      size_q  <= SZ_WORD;
      off_q   <= '0;
      wdata_q <= '0;
      word_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          addr_q  <= dec_addr;
          err_q   <= dec_err;
          we_q    <= req_write;
          fix_q   <= is_fix;
          size_q  <= req_size;
          off_q   <= req_off[1:0];
          wdata_q <= req_wdata;
          st      <= dec_err ? ST_ERR : ST_RD;
        end
        ST_RD: if (mem_ack) begin
          if (we_q) begin
            word_q  <= lane_merged;
            rdata_q <= '0;
            st      <= ST_WR;
          end else begin
            rdata_q <= lane_rd;
            st      <= ST_DONE;
          end
        end
        ST_WR: if (mem_ack) st <= ST_DONE;
        ST_ERR: begin
          rdata_q <= we_q ? '0 : lane_rd;
          st      <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign mem_req    = (st == ST_RD) || (st == ST_WR);
  assign mem_we     = (st == ST_WR);
  assign mem_addr   = addr_q;
  assign mem_wdata  = word_q;
  assign done       = (st == ST_DONE);
  assign done_err   = err_q;
  assign done_rdata = rdata_q;
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          done,
  input logic          done_err
);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && (mem_we == $past(mem_we))));

  a_r10_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  a_r10_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_wr_after_rd: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(mem_ack && mem_req && !mem_we));

  a_r6_err_no_mem: assert property (@(posedge clk) disable iff (rst)
    (done && done_err) |-> !$past(mem_req));

  a_r11_reset: assert property (@(posedge clk)
    $past(rst) |-> (req_ready && !mem_req && !done));
endmodule

bind cfg_xlate_top cfg_xlate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .done(done), .done_err(done_err)
);

// File: tb/sim_cfg_xlate_top.sv
module sim_cfg_xlate_top;
  localparam int NP = 3;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic           legacy_mode = 1'b0;
  logic [NP-1:0]  port_en = 3'b011;
  logic [NP*AW-1:0] port_base = {32'h1002_0000, 32'h1001_0000, 32'h1000_0000};
  logic [AW-1:0]  ext_base = 32'h2000_0000;
  logic           req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]     req_bus = '0;
  logic [4:0]     req_dev = '0;
  logic [2:0]     req_func = '0;
  logic [11:0]    req_off = '0;
  logic [1:0]     req_size = 2'd2;
  logic [31:0]    req_wdata = '0;
  logic           req_ready, mem_req, mem_we, done, done_err;
  logic [AW-1:0]  mem_addr;
  logic [31:0]    mem_wdata, mem_rdata, done_rdata;
  logic           mem_ack = 1'b0;

  cfg_xlate_top #(.NUM_PORTS(NP), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .port_en(port_en),
    .port_base(port_base), .ext_base(ext_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_bus(req_bus),
    .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
    .req_size(req_size), .req_wdata(req_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .done_err(done_err), .done_rdata(done_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;

  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else mem_ack <= mem_req && !mem_ack;
    if (!rst && mem_req && mem_ack) begin
      if (mem_we) begin
        wr_cnt  <= wr_cnt + 1;
        wr_addr <= mem_addr;
        wr_data <= mem_wdata;
      end else begin
        rd_cnt  <= rd_cnt + 1;
        rd_addr <= mem_addr;
      end
    end
  end

  int total = 0, bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [31:0] raw, input logic fix,
                                           input logic [1:0] sz, input logic [1:0] off);
    logic [31:0] w;
    w = raw;
    if (fix) w[23:16] = 8'h04;
    case (sz)
      2'd0: return {24'h0, w[8*off +: 8]};
      2'd1: return {16'h0, w[16*off[1] +: 16]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [31:0] wd,
                                            input logic [1:0] sz, input logic [1:0] off);
    logic [31:0] w;
    w = old;
    case (sz)
      2'd0: w[8*off +: 8] = wd[7:0];
      2'd1: w[16*off[1] +: 16] = wd[15:0];
      default: w = wd;
    endcase
    return w;
  endfunction

  typedef struct packed {
    logic        wr;
    logic        leg;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] off;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic        eerr;
    logic [31:0] eaddr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,8'd0,  5'd1, 3'd0,12'h010,2'd2,32'h0,       1'b0,32'h1000_0010}, // R1 R9 word
    '{1'b0,1'b0,8'd0,  5'd2, 3'd0,12'h107,2'd0,32'h0,       1'b0,32'h1001_0104}, // R1 R9 byte lane 3
    '{1'b0,1'b0,8'd0,  5'd3, 3'd0,12'h000,2'd2,32'h0,       1'b1,32'h0},         // R2 R6 disabled port
    '{1'b0,1'b0,8'd0,  5'd0, 3'd0,12'h004,2'd1,32'h0,       1'b1,32'h0},         // R2 R6 device 0
    '{1'b0,1'b0,8'd5,  5'd3, 3'd2,12'h2A6,2'd1,32'h0,       1'b0,32'h2205_1AA4}, // R3 R9 half
    '{1'b1,1'b0,8'd0,  5'd1, 3'd0,12'h005,2'd0,32'hAB,      1'b0,32'h1000_0004}, // R8 byte
    '{1'b1,1'b0,8'd1,  5'd0, 3'd0,12'hFFE,2'd1,32'hBEEF,    1'b0,32'h2F01_00FC}, // R8 R3 half
    '{1'b1,1'b0,8'd0,  5'd3, 3'd0,12'h020,2'd2,32'hDEADBEEF,1'b1,32'h0},         // R7
    '{1'b0,1'b1,8'd2,  5'd1, 3'd0,12'h040,2'd2,32'h0,       1'b1,32'h0},         // R4 error
    '{1'b0,1'b1,8'd2,  5'd0, 3'd1,12'h040,2'd2,32'h0,       1'b0,32'h2002_0140}, // R4 allowed
    '{1'b0,1'b1,8'd0,  5'd1, 3'd0,12'h008,2'd2,32'h0,       1'b0,32'h1000_0008}, // R5 fixup word
    '{1'b0,1'b0,8'd0,  5'd2, 3'd0,12'h00A,2'd1,32'h0,       1'b0,32'h1001_0008}, // R5 no strap
    '{1'b0,1'b1,8'd0,  5'd2, 3'd0,12'h00A,2'd1,32'h0,       1'b0,32'h1001_0008}, // R5 fixup half
    '{1'b1,1'b0,8'd0,  5'd2, 3'd0,12'h020,2'd2,32'h12345678,1'b0,32'h1001_0020}, // R8 word
    '{1'b0,1'b0,8'd255,5'd31,3'd7,12'h3FC,2'd2,32'h0,       1'b0,32'h23FF_FFFC}, // R3 all ones fields
    '{1'b1,1'b1,8'd3,  5'd2, 3'd0,12'h010,2'd2,32'h1,       1'b1,32'h0},         // R4 R7
    '{1'b0,1'b1,8'd3,  5'd0, 3'd0,12'h008,2'd2,32'h0,       1'b0,32'h2003_0008}, // R5 other bus
    '{1'b0,1'b1,8'd0,  5'd3, 3'd0,12'h008,2'd2,32'h0,       1'b1,32'h0}          // R5 R6 error read
  };
  localparam string TAGS [NV] = '{"R1","R9","R6","R6","R3","R8","R8","R7","R4","R4",
                                  "R5","R5","R5","R8","R3","R7","R5","R6"};

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic run_access(input vec_t v, output logic err, output logic [31:0] rd, output bit ok);
    int g;
    ok = 1'b1;
    @(negedge clk);
    legacy_mode = v.leg; req_write = v.wr; req_bus = v.bus; req_dev = v.dev;
    req_func = v.fn; req_off = v.off; req_size = v.sz; req_wdata = v.wd;
    req_valid = 1'b1;
    g = 0;
    while (!req_ready && g < 100) begin @(negedge clk); g++; end
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 ready low after accept", {31'h0, req_ready}, 32'h0);
    g = 0;
    while (!done && g < 100) begin @(negedge clk); g++; end
    if (!done) ok = 1'b0;
    err = done_err;
    rd  = done_rdata;
    @(negedge clk);
    check("R10 done one cycle", {31'h0, done}, 32'h0);
  endtask

  initial begin
    int rc0, wc0;
    logic e;
    logic [31:0] r;
    bit ok;
    repeat (3) @(negedge clk);
    check("R11 ready in reset", {31'h0, req_ready}, 32'h1);
    check("R11 mem_req in reset", {31'h0, mem_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 done after reset", {31'h0, done}, 32'h0);
    check("R11 ready after reset", {31'h0, req_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic fix;
      v = VECS[i];
      rc0 = rd_cnt; wc0 = wr_cnt;
      run_access(v, e, r, ok);
      if (!ok) check({TAGS[i], " no completion"}, 32'h0, 32'h1);
      check({TAGS[i], " error flag"}, {31'h0, e}, {31'h0, v.eerr});
      fix = v.leg && !v.wr && !v.eerr && (v.bus == 0) && (v.off[11:2] == 10'd2);
      if (v.eerr) begin
        check({TAGS[i], " no mem read on error"}, rd_cnt, rc0);
        check({TAGS[i], " no mem write on error"}, wr_cnt, wc0);
        if (!v.wr) check({TAGS[i], " error read data"}, r, exp_read('1, 1'b0, v.sz, v.off[1:0]));
      end else begin
        check({TAGS[i], " one read"}, rd_cnt, rc0 + 1);
        check({TAGS[i], " read address"}, rd_addr, v.eaddr);
        if (v.wr) begin
          check({TAGS[i], " one write"}, wr_cnt, wc0 + 1);
          check({TAGS[i], " write address"}, wr_addr, v.eaddr);
          check({TAGS[i], " merged word"}, wr_data,
                exp_merge(mem_word(v.eaddr), v.wd, v.sz, v.off[1:0]));
        end else begin
          check({TAGS[i], " read data"}, r, exp_read(mem_word(v.eaddr), fix, v.sz, v.off[1:0]));
        end
      end
    end

    // R11: reset in the middle of an access returns to idle
    @(negedge clk);
    legacy_mode = 1'b0; req_write = 1'b0; req_bus = 8'd0; req_dev = 5'd1;
    req_off = 12'h0; req_size = 2'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 mem_req while busy", {31'h0, mem_req}, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 idle after mid reset", {30'h0, req_ready, mem_req}, 32'h2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=<50000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule